// File: doc/BRIEF.md
# Watchdog Timer with Programmable Postscaler

The block is a supervisory timer that runs off a slow clock-enable tick from an internal low-speed oscillator. Each tick advances a fixed prescaler. Every time the prescaler wraps it produces one base period, and a postscaler counts these base periods. A 4-bit select value sets the timeout to one of sixteen power-of-two multiples of the base period, from 1 up to 32,768.

Firmware must keep restarting the count before it expires. A clear command does this. Entering sleep, a change of oscillator frequency setting, a detected clock failure and device reset also restart the count. When the count does expire, the block emits a single-cycle reset request if the core is awake, or a single-cycle wake-up request if the core is asleep.

The timer is switched on by a hardware enable. When that enable is low, a software enable controls it instead. Whenever the timer is on, the block also asks for the low-speed oscillator to keep running.

Top module: `wdog_timer`

## Requirements
- R1: The prescaler counts PRE_DIV enabled ticks (tick_i high) per base period. With select value n and no restart, the timeout fires after exactly PRE_DIV * 2^n ticks since the last restart.
- R2: The 4-bit select value n (0 to 15) picks a ratio of 2^n base periods. Value 15 gives 32,768 base periods.
- R3: A clear command strobe (clr_i high for one cycle) restarts both counts from zero. The full period is then needed again before a timeout.
- R4: A sleep-entry strobe (sleep_enter_i) restarts both counts from zero.
- R5: An oscillator-setting-change strobe (osc_chg_i) restarts both counts from zero.
- R6: A clock-failure strobe (clk_fail_i) restarts both counts from zero. Asserting rst_ni low does the same and drives both pulse outputs low.
- R7: The timer runs when hw_en_i is 1, whatever the value of sw_en_i. When hw_en_i is 0, the timer runs only while sw_en_i is 1.
- R8: osc_req_o is 1 in every cycle in which the timer is enabled, and 0 otherwise.
- R9: A timeout while asleep_i is 0 drives wdt_rst_o high for exactly one cycle, in the cycle after the final tick. Counting then restarts from zero.
- R10: A timeout while asleep_i is 1 drives wake_o high for one cycle instead, and wdt_rst_o stays 0. The two outputs are never high together.
- R11: A change of the select value does not restart the counts. The new value is compared at the next base period boundary. If the count already reached the new limit, the timeout fires there.
- R12: While the timer is disabled, the counts are held at zero and neither pulse output goes high.
- R13: In cycles where tick_i is 0, the counts do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous device reset |
| tick_i | input | 1 | Clock enable from the low-speed oscillator |
| hw_en_i | input | 1 | Hardware (fused) enable |
| sw_en_i | input | 1 | Software enable, used only while hw_en_i is 0 |
| period_sel_i | input | 4 | Postscaler select, ratio 2^value |
| clr_i | input | 1 | Clear command strobe |
| sleep_enter_i | input | 1 | Sleep-entry strobe |
| osc_chg_i | input | 1 | Oscillator frequency-setting change strobe |
| clk_fail_i | input | 1 | Clock failure strobe |
| asleep_i | input | 1 | Core is in a power-managed sleep state |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |
| wake_o | output | 1 | One-cycle wake-up request |
| osc_req_o | output | 1 | Request to keep the low-speed oscillator running |

## Verification
The hardest case to reach from the ports is the longest select value, which needs 2^15 base periods. The bench builds the block with a prescaler of 2 so that this full span fits in one run. Directed tests cover two other awkward cases: a select value lowered below a count already reached, and a restart strobe landing near expiry. A long random phase with sparse ticks, rare strobes and toggling enables then lines up strobes with the terminal tick, and a cycle-accurate bench model checks every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic clr_cmd;
    logic sleep_entry;
    logic osc_change;
    logic clk_fail;
  } wdog_clr_src_t;

  function automatic logic any_clear(wdog_clr_src_t s);
    return |s;
  endfunction
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_en_i,
  input  logic          sw_en_i,
  input  wdog_clr_src_t src_i,
  output logic          run_o,
  output logic          clear_o
);
  // software bit only matters when the fuse leaves the timer off
  always_comb begin
    if (hw_en_i) run_o = 1'b1;
    else         run_o = sw_en_i;
  end

  // disabled timer is held at zero by the same path as a restart
  assign clear_o = ~run_o | any_clear(src_i);

  assert_hw_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_en_i |-> run_o);
  assert_off_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_en_i && !sw_en_i) |-> clear_o);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic base_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_next;
  logic             pre_last;

  assign pre_last = (pre_q == LAST);
  assign base_o   = tick_i & ~clear_i & pre_last;

  generate
    if ((1 << PRE_W) == PRE_DIV) begin : g_pow2
      assign pre_next = pre_q + 1'b1;
    end else begin : g_mod
      assign pre_next = pre_last ? '0 : pre_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (tick_i)  pre_q <= pre_next;
  end

  assert_pre_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pre_q == '0));
  assert_pre_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(pre_q));
endmodule

// File: rtl/wdog_postscaler.sv
module wdog_postscaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             asleep_i,
  output logic             rst_o,
  output logic             wake_o
);
  localparam int POST_W = (1 << SEL_W) - 1;
  localparam logic [POST_W:0] ONE = 1;

  logic [POST_W-1:0] post_q;
  logic [POST_W:0]   ratio;
  logic [POST_W-1:0] lim;
  logic              fire;
  logic              rst_q, wake_q;

  assign ratio = ONE << sel_i;
  assign lim   = POST_W'(ratio - 1'b1);
  // >= so a lowered select fires at the next boundary instead of wrapping
  assign fire  = base_i & (post_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      post_q <= '0;
    else if (clear_i) post_q <= '0;
    else if (fire)    post_q <= '0;
    else if (base_i)  post_q <= post_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      rst_q  <= fire & ~asleep_i;
      wake_q <= fire & asleep_i;
    end
  end

  assign rst_o  = rst_q;
  assign wake_o = wake_q;

  assert_post_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (post_q == '0));
  assert_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  assert_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_q && wake_q));
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_q || wake_q) |-> (post_q == '0));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int PRE_DIV = 128,
  parameter int SEL_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hw_en_i,
  input  logic             sw_en_i,
  input  logic [SEL_W-1:0] period_sel_i,
  input  logic             clr_i,
  input  logic             sleep_enter_i,
  input  logic             osc_chg_i,
  input  logic             clk_fail_i,
  input  logic             asleep_i,
  output logic             wdt_rst_o,
  output logic             wake_o,
  output logic             osc_req_o
);
  wdog_clr_src_t src;
  logic run, clear, base;

  assign src = '{clr_cmd: clr_i, sleep_entry: sleep_enter_i,
                 osc_change: osc_chg_i, clk_fail: clk_fail_i};

  wdog_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_en_i (hw_en_i),
    .sw_en_i (sw_en_i),
    .src_i   (src),
    .run_o   (run),
    .clear_o (clear)
  );

  wdog_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clear_i (clear),
    .base_o  (base)
  );

  wdog_postscaler #(.SEL_W(SEL_W)) u_post (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .base_i   (base),
    .clear_i  (clear),
    .sel_i    (period_sel_i),
    .asleep_i (asleep_i),
    .rst_o    (wdt_rst_o),
    .wake_o   (wake_o)
  );

  assign osc_req_o = run;

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_req_o |=> !(wdt_rst_o || wake_o));
  assert_sw_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_en_i |-> osc_req_o);
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int PRE = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0, hw_en = 1'b0, sw_en = 1'b0;
  logic [3:0] sel = 4'd0;
  logic clr = 1'b0, slp = 1'b0, oscc = 1'b0, cfail = 1'b0, asleep = 1'b0;
  logic wdt_rst_o, wake_o, osc_req_o;

  int errors = 0, checks = 0;
  int m = 0;
  logic exp_rst = 1'b0, exp_wake = 1'b0;
  string cur_req = "R9";
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_timer #(.PRE_DIV(PRE), .SEL_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .hw_en_i(hw_en), .sw_en_i(sw_en),
    .period_sel_i(sel), .clr_i(clr), .sleep_enter_i(slp), .osc_chg_i(oscc),
    .clk_fail_i(cfail), .asleep_i(asleep), .wdt_rst_o(wdt_rst_o), .wake_o(wake_o),
    .osc_req_o(osc_req_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int period(input logic [3:0] s);
    return PRE << s;
  endfunction

  // one clock: model the edge from current inputs, then compare after it
  task automatic apply();
    logic run, any_clr, fire;
    int m1;
    #1;
    run = hw_en | sw_en;
    check(osc_req_o == run, "R8", int'(osc_req_o), int'(run));
    any_clr = clr | slp | oscc | cfail;
    fire = 1'b0;
    if (!run || any_clr) m = 0;
    else if (tick) begin
      m1 = m + 1;
      if ((m1 % PRE) == 0 && (m1 / PRE) >= (1 << sel)) begin
        fire = 1'b1;
        m = 0;
      end else m = m1;
    end
    exp_rst  = fire & ~asleep;
    exp_wake = fire & asleep;
    @(negedge clk);
    check(wdt_rst_o == exp_rst && wake_o == exp_wake, cur_req,
          {wdt_rst_o, wake_o}, {exp_rst, exp_wake});
    clr = 1'b0; slp = 1'b0; oscc = 1'b0; cfail = 1'b0;
  endtask

  task automatic measure(input int exp_len, input string req, output bit woke);
    int n = 0;
    do begin
      apply();
      n++;
    end while (!(wdt_rst_o || wake_o) && n < exp_len + 64);
    woke = wake_o;
    check(n == exp_len, req, n, exp_len);
  endtask

  task automatic restart();
    clr = 1'b1;
    apply();
  endtask

  initial begin
    bit w;
    int r;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    // reset state
    check(wdt_rst_o == 1'b0 && wake_o == 1'b0, "R6", {wdt_rst_o, wake_o}, 0);
    check(osc_req_o == 1'b0, "R8", int'(osc_req_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 / R9: base period and ratio
    cur_req = "R1";
    hw_en = 1'b1; tick = 1'b1; sel = 4'd0;
    restart();
    measure(period(0), "R1", w);
    check(w == 1'b0, "R9", int'(w), 0);
    cur_req = "R9";
    measure(period(0), "R9", w);
    sel = 4'd3;
    measure(period(3), "R1", w);

    // R13: sparse ticks double the wall time
    cur_req = "R13";
    sel = 4'd2;
    restart();
    begin
      int n = 0;
      do begin
        tick = n[0];
        apply();
        n++;
      end while (!wdt_rst_o && n < 200);
      check(n == 2 * period(2), "R13", n, 2 * period(2));
    end
    tick = 1'b1;

    // R3..R6: each restart source
    sel = 4'd3;
    cur_req = "R3";
    restart();
    repeat (period(3) - 1) apply();
    clr = 1'b1; apply();
    measure(period(3), "R3", w);
    cur_req = "R4";
    repeat (period(3) - 2) apply();
    slp = 1'b1; apply();
    measure(period(3), "R4", w);
    cur_req = "R5";
    repeat (5) apply();
    oscc = 1'b1; apply();
    measure(period(3), "R5", w);
    cur_req = "R6";
    repeat (7) apply();
    cfail = 1'b1; apply();
    measure(period(3), "R6", w);
    repeat (9) apply();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(wdt_rst_o == 1'b0 && wake_o == 1'b0, "R6", {wdt_rst_o, wake_o}, 0);
    m = 0;
    rst_ni = 1'b1;
    measure(period(3), "R6", w);

    // R10: asleep gives wake
    cur_req = "R10";
    asleep = 1'b1;
    measure(period(3), "R10", w);
    check(w == 1'b1, "R10", int'(w), 1);
    asleep = 1'b0;

    // R7 / R12: enable combinations
    cur_req = "R7";
    sel = 4'd1;
    hw_en = 1'b0; sw_en = 1'b1;
    restart();
    measure(period(1), "R7", w);
    cur_req = "R12";
    sw_en = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 50; i++) begin
        apply();
        if (wdt_rst_o || wake_o) seen++;
      end
      check(seen == 0, "R12", seen, 0);
    end
    sw_en = 1'b1;
    measure(period(1), "R12", w);
    cur_req = "R7";
    hw_en = 1'b1; sw_en = 1'b0;
    restart();
    apply();
    sw_en = 1'b1;
    apply();
    sw_en = 1'b0;
    measure(period(1) - 2, "R7", w);

    // R11: lowered select fires at next boundary
    cur_req = "R11";
    sel = 4'd4;
    restart();
    repeat (10 * PRE) apply();
    sel = 4'd2;
    measure(PRE, "R11", w);

    // R2: longest setting
    cur_req = "R2";
    sel = 4'd15;
    restart();
    measure(period(15), "R2", w);

    // random mix
    cur_req = "R9";
    hw_en = 1'b1; sw_en = 1'b0; sel = 4'd1;
    for (int i = 0; i < 20000; i++) begin
      r = $urandom;
      tick  = (r[1:0] != 2'b00);
      if (r[8:4] == 5'd0) hw_en = ~hw_en;
      if (r[12:9] == 4'd0) sw_en = ~sw_en;
      if (r[17:13] == 5'd0) sel = 4'(r[19:18]);
      clr   = (r[25:20] == 6'd1);
      slp   = (r[25:20] == 6'd2);
      oscc  = (r[25:20] == 6'd3);
      cfail = (r[25:20] == 6'd4);
      if (r[30:27] == 4'd0) asleep = ~asleep;
      apply();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule